// File: doc/BRIEF.md
# Locked-Rotor Fault Detector

This block sits beside the commutation logic of a three-phase brushless motor pre-driver and decides when the rotor has stalled. It watches two things: the speed-feedback line, which should change state at every Hall transition, and the stream of 3-bit Hall codes, which should advance one step at a time in the order that matches the direction input. If either stops making progress for a set number of ticks of a slow timebase, it raises a fault. The timebase arrives as a single-cycle `tick` strobe from an external oscillator. The bridge logic uses the fault to turn the gate drivers off.

Once set, the fault stays set until one of these happens: the direction input changes level, the block is reset at power-up, or the drive-off input stays high for half the lock window. Brake mode freezes both timers at zero. Pulling the detect-enable input low switches the whole function off.

Top module: `rotor_lock_detector`

## Requirements
- R1: After reset `lockFault` is low and both lock timers start from zero.
- R2: Two lock timers run. Each counts `tick` pulses. When a timer's count reaches LOCK_TICKS (default 127) with no restart, `lockFault` goes high on the clock after that tick.
- R3: Any change of level on `speedFb` restarts the no-edge timer.
- R4: A Hall change to the next code in order restarts the sequence timer. With `dirIn`=1 the order is 101,100,110,010,011,001 and then back to 101, written as {A,B,C} with A as the MSB. With `dirIn`=0 the order is the reverse of that.
- R5: A Hall change that is not the next code for the current direction does not restart the sequence timer. This includes a step in the wrong direction and any step to or from 000 or 111.
- R6: A Hall change back to the code seen two transitions earlier is a toggle. A toggle never restarts the sequence timer, even when it matches the order for the current direction, as happens right after a direction reversal.
- R7: Once set, `lockFault` stays high while speed-feedback edges and in-order Hall steps continue.
- R8: A level change on `dirIn` clears `lockFault` and zeroes both timers.
- R9: `driveOff` held high for HALF_TICKS ticks (LOCK_TICKS+1)/2, which is 64 by default, clears `lockFault` and keeps the timers at zero while it stays high. A shorter high pulse clears nothing.
- R10: While `brakeOn` is high both timers are held at zero and `lockFault` keeps its value. A `dirIn` change still clears it.
- R11: While `detectEn` is low, `lockFault` is low from the next clock and the timers stay at zero.
- R12: An active-low reset clears a latched fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up / undervoltage reset |
| detectEn | input | 1 | High enables lock detection |
| brakeOn | input | 1 | High while the bridge is braking |
| driveOff | input | 1 | High while the drive enable is off (chopped) |
| dirIn | input | 1 | Rotation direction, 1 = forward |
| speedFb | input | 1 | Speed-feedback level, toggles per Hall transition |
| hallCode | input | 3 | Hall sensor code {A,B,C} |
| tick | input | 1 | One-cycle pulse from the slow lock timebase |
| lockFault | output | 1 | Latched locked-rotor fault |

## Verification
The first pattern keeps the Hall steps in order but holds `speedFb` still. The second toggles `speedFb` while the Hall steps run in the wrong direction. Together they show that each timer fires on its own at exactly tick 127 and that each restarts only on its own kind of event. A reversal followed by a step back to the previous code separates toggle rejection from plain order checking. Long and short `driveOff` pulses, a stretch of brake with and without a direction flip, and the disable input each test one clear or hold path. A behavioural model compares `lockFault` on every clock.

// File: rtl/rotor_lock_pkg.sv
package rotor_lock_pkg;

  // events reported by the datapath to the control
  typedef struct packed {
    logic dirEdge;   // direction input changed level
    logic fbEdge;    // speed-feedback changed level
    logic goodStep;  // in-order, non-toggle Hall step
    logic stallHit;  // no-edge timer completes on this tick
    logic seqHit;    // sequence timer completes on this tick
    logic offLong;   // drive-off held for half the lock window
  } lock_evt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic zeroTimers;
  } lock_ctl_t;

  // next Hall code in commutation order; an illegal code maps to itself
  function automatic logic [2:0] nextHall(input logic [2:0] cur, input logic fwd);
    logic [2:0] nxt;
    nxt = cur;
    if (fwd) begin
      case (cur)
        3'b101: nxt = 3'b100;
        3'b100: nxt = 3'b110;
        3'b110: nxt = 3'b010;
        3'b010: nxt = 3'b011;
        3'b011: nxt = 3'b001;
        3'b001: nxt = 3'b101;
        default: nxt = cur;
      endcase
    end else begin
      case (cur)
        3'b101: nxt = 3'b001;
        3'b001: nxt = 3'b011;
        3'b011: nxt = 3'b010;
        3'b010: nxt = 3'b110;
        3'b110: nxt = 3'b100;
        3'b100: nxt = 3'b101;
        default: nxt = cur;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/rotor_lock_datapath.sv
module rotor_lock_datapath
  import rotor_lock_pkg::*;
#(
  parameter int LOCK_TICKS = 127,
  parameter int HALF_TICKS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dirIn,
  input  logic       speedFb,
  input  logic [2:0] hallCode,
  input  logic       tick,
  input  logic       driveOff,
  input  lock_ctl_t  ctl,
  output lock_evt_t  evt
);

  localparam int CNT_W = $clog2(LOCK_TICKS + 1);
  localparam int OFF_W = $clog2(HALF_TICKS + 1);
  localparam logic [CNT_W-1:0] LOCK_MAX  = CNT_W'(LOCK_TICKS);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_TICKS - 1);
  localparam logic [OFF_W-1:0] OFF_FULL  = OFF_W'(HALF_TICKS);
  localparam int NUM_TIMERS = 2;  // 0: no-edge, 1: sequence

  logic             dirPrev;
  logic             fbPrev;
  logic [2:0]       hallPrev;
  logic [2:0]       hallPrev2;
  logic [OFF_W-1:0] offCnt;
  logic             hallMoved;
  logic             inOrder;
  logic [NUM_TIMERS-1:0] restart;
  logic [NUM_TIMERS-1:0] hit;

  assign hallMoved = (hallCode != hallPrev);
  assign inOrder   = hallMoved
                   && (hallCode == nextHall(hallPrev, dirIn))
                   && (hallCode != hallPrev2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirPrev   <= 1'b0;
      fbPrev    <= 1'b0;
      hallPrev  <= 3'b000;
      hallPrev2 <= 3'b000;
    end else begin
      dirPrev <= dirIn;
      fbPrev  <= speedFb;
      if (hallMoved) begin
        hallPrev2 <= hallPrev;
        hallPrev  <= hallCode;
      end
    end
  end

  assign restart[0] = (speedFb != fbPrev);
  assign restart[1] = inOrder;

  generate
    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_timer
      logic [CNT_W-1:0] lockCnt;

      always_ff @(posedge clk) begin
        if (!rstN)
          lockCnt <= '0;
        else if (ctl.zeroTimers || restart[g])
          lockCnt <= '0;
        else if (tick && lockCnt != LOCK_MAX)
          lockCnt <= lockCnt + 1'b1;
      end

      assign hit[g] = tick && !restart[g] && (lockCnt == LOCK_LAST);

      assert_timer_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
        lockCnt <= LOCK_MAX);
      assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
        restart[g] |=> lockCnt == '0);
      assert_zero_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
        ctl.zeroTimers |=> lockCnt == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)
      offCnt <= '0;
    else if (!driveOff)
      offCnt <= '0;
    else if (tick && offCnt != OFF_FULL)
      offCnt <= offCnt + 1'b1;
  end

  assert_off_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    offCnt <= OFF_FULL);

  always_comb begin
    evt.dirEdge  = (dirIn != dirPrev);
    evt.fbEdge   = restart[0];
    evt.goodStep = restart[1];
    evt.stallHit = hit[0];
    evt.seqHit   = hit[1];
    evt.offLong  = driveOff && (offCnt == OFF_FULL);
  end

endmodule

// File: rtl/rotor_lock_control.sv
module rotor_lock_control
  import rotor_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      detectEn,
  input  logic      brakeOn,
  input  lock_evt_t evt,
  output lock_ctl_t ctl,
  output logic      lockFault
);

  logic clearReq;

  assign clearReq = evt.dirEdge || evt.offLong;

  always_comb begin
    ctl.zeroTimers = !detectEn || brakeOn || clearReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      lockFault <= 1'b0;
    else if (!detectEn || clearReq)
      lockFault <= 1'b0;
    else if (!brakeOn && (evt.stallHit || evt.seqHit))
      lockFault <= 1'b1;
  end

  assert_disabled_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    !detectEn |=> !lockFault);
  assert_dir_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    evt.dirEdge |=> !lockFault);
  assert_off_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    evt.offLong |=> !lockFault);
  assert_brake_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (detectEn && brakeOn && !clearReq) |=> $stable(lockFault));
  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockFault) |-> $past(evt.stallHit || evt.seqHit));
  assert_latched_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lockFault && detectEn && !clearReq) |=> lockFault);

endmodule

// File: rtl/rotor_lock_detector.sv
module rotor_lock_detector
  import rotor_lock_pkg::*;
#(
  parameter int LOCK_TICKS = 127
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       detectEn,
  input  logic       brakeOn,
  input  logic       driveOff,
  input  logic       dirIn,
  input  logic       speedFb,
  input  logic [2:0] hallCode,
  input  logic       tick,
  output logic       lockFault
);

  localparam int HALF_TICKS = (LOCK_TICKS + 1) / 2;

  lock_evt_t evt;
  lock_ctl_t ctl;

  rotor_lock_datapath #(
    .LOCK_TICKS(LOCK_TICKS),
    .HALF_TICKS(HALF_TICKS)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .dirIn   (dirIn),
    .speedFb (speedFb),
    .hallCode(hallCode),
    .tick    (tick),
    .driveOff(driveOff),
    .ctl     (ctl),
    .evt     (evt)
  );

  rotor_lock_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .detectEn (detectEn),
    .brakeOn  (brakeOn),
    .evt      (evt),
    .ctl      (ctl),
    .lockFault(lockFault)
  );

endmodule

// File: tb/rotor_lock_detector_bench.sv
`timescale 1ns/1ps
module rotor_lock_detector_bench;

  localparam int LOCK = 127;
  localparam int HALF = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic detectEn = 1'b1;
  logic brakeOn = 1'b0;
  logic driveOff = 1'b0;
  logic dirIn = 1'b1;
  logic speedFb = 1'b0;
  logic [2:0] hallCode = 3'b101;
  logic tick = 1'b0;
  logic lockFault;

  int total = 0;
  int bad = 0;
  int fbAuto = 0;     // toggle speedFb every 10 ticks
  int hallMode = 0;   // 0 hold, 1 forward order, 2 reverse order
  int tickCount = 0;

  always #5 clk = ~clk;

  rotor_lock_detector u_rotor_lock_detector (
    .clk(clk), .rstN(rstN), .detectEn(detectEn), .brakeOn(brakeOn),
    .driveOff(driveOff), .dirIn(dirIn), .speedFb(speedFb),
    .hallCode(hallCode), .tick(tick), .lockFault(lockFault)
  );

  function automatic logic [2:0] stepCode(input logic [2:0] cur, input bit fwd);
    int ord[6] = '{5, 4, 6, 2, 3, 1};
    for (int i = 0; i < 6; i++)
      if (ord[i] == int'(cur)) return fwd ? 3'(ord[(i + 1) % 6]) : 3'(ord[(i + 5) % 6]);
    return cur;
  endfunction

  // behavioural reference model
  int mStall, mSeq, mOff;
  bit mFault, mPrevDir, mPrevFb;
  logic [2:0] mPrev, mPrev2;

  always @(posedge clk) begin
    bit dirE, fbE, good, clr, hitS, hitQ;
    if (!rstN) begin
      mStall = 0; mSeq = 0; mOff = 0; mFault = 0;
      mPrevDir = 0; mPrevFb = 0; mPrev = 3'b000; mPrev2 = 3'b000;
    end else begin
      dirE = (dirIn != mPrevDir);
      fbE  = (speedFb != mPrevFb);
      good = (hallCode != mPrev) && (hallCode == stepCode(mPrev, dirIn)) && (hallCode != mPrev2);
      clr  = dirE || (driveOff && mOff >= HALF);
      hitS = tick && !fbE && (mStall == LOCK - 1);
      hitQ = tick && !good && (mSeq == LOCK - 1);
      if (!detectEn || clr) mFault = 0;
      else if (!brakeOn && (hitS || hitQ)) mFault = 1;
      if (!detectEn || brakeOn || clr) begin
        mStall = 0; mSeq = 0;
      end else begin
        if (fbE) mStall = 0; else if (tick && mStall < LOCK) mStall++;
        if (good) mSeq = 0; else if (tick && mSeq < LOCK) mSeq++;
      end
      if (!driveOff) mOff = 0; else if (tick && mOff < HALF) mOff++;
      mPrevDir = dirIn;
      mPrevFb = speedFb;
      if (hallCode != mPrev) begin
        mPrev2 = mPrev;
        mPrev = hallCode;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      total++;
      if (lockFault !== mFault) begin
        bad++;
        $display("FAIL model R2 R3 R4 R5 R6 R7 R8 R9 R10 R11: lockFault=%0b expected=%0b t=%0t",
                 lockFault, mFault, $time);
      end
    end
  end

  task automatic check(input bit expVal, input string req);
    total++;
    if (lockFault !== expVal) begin
      bad++;
      $display("FAIL %s: lockFault=%0b expected=%0b", req, lockFault, expVal);
    end
  endtask

  task automatic runTicks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      tickCount++;
      if (tickCount % 10 == 5) begin
        if (fbAuto != 0) speedFb = ~speedFb;
        if (hallMode == 1) hallCode = stepCode(hallCode, 1);
        else if (hallMode == 2) hallCode = stepCode(hallCode, 0);
      end
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 reset state");

    // R2/R4: in-order Hall steps, frozen speed feedback
    hallMode = 1; fbAuto = 0;
    runTicks(LOCK - 1);
    check(1'b0, "R4 before no-edge timeout");
    runTicks(1);
    check(1'b1, "R2 no-edge timeout at 127");

    // R7: progress resumes, fault stays latched
    fbAuto = 1;
    runTicks(30);
    check(1'b1, "R7 latched under progress");

    // R8: direction flip clears
    @(negedge clk) dirIn = 1'b0;
    repeat (2) @(negedge clk);
    check(1'b0, "R8 direction edge clear");

    // R3/R5: feedback toggles, Hall steps in wrong direction
    runTicks(LOCK - 1);
    check(1'b0, "R3 before sequence timeout");
    runTicks(1);
    check(1'b1, "R5 wrong-order timeout at 127");

    // R9: short drive-off pulse leaves fault, long one clears
    driveOff = 1'b1;
    runTicks(30);
    driveOff = 1'b0;
    @(negedge clk);
    check(1'b1, "R9 short drive-off no clear");
    driveOff = 1'b1;
    runTicks(HALF - 1);
    check(1'b1, "R9 drive-off one tick short");
    runTicks(1);
    check(1'b0, "R9 drive-off half window clear");
    runTicks(200);
    check(1'b0, "R9 held clear while drive-off");
    driveOff = 1'b0;

    // R6: reverse steps, reversal, then step back to code two earlier
    hallMode = 0;
    @(negedge clk) hallCode = stepCode(hallCode, 0);
    repeat (2) @(negedge clk);
    hallCode = stepCode(hallCode, 0);
    repeat (2) @(negedge clk);
    dirIn = 1'b1;
    runTicks(5);
    hallCode = stepCode(hallCode, 1);
    runTicks(LOCK - 6);
    check(1'b0, "R6 before toggle timeout");
    runTicks(1);
    check(1'b1, "R6 toggle did not restart");

    // R10: brake holds fault, then holds timers at zero
    fbAuto = 0;
    brakeOn = 1'b1;
    runTicks(200);
    check(1'b1, "R10 brake keeps fault");
    dirIn = 1'b0;
    repeat (2) @(negedge clk);
    check(1'b0, "R10 direction clear in brake");
    runTicks(200);
    check(1'b0, "R10 timers frozen in brake");
    brakeOn = 1'b0;
    runTicks(LOCK - 1);
    check(1'b0, "R10 timers restarted from zero");
    runTicks(1);
    check(1'b1, "R10 timeout after brake");

    // R11: disable
    detectEn = 1'b0;
    repeat (2) @(negedge clk);
    check(1'b0, "R11 disable clears");
    runTicks(200);
    check(1'b0, "R11 stays low while disabled");
    detectEn = 1'b1;
    runTicks(LOCK - 1);
    check(1'b0, "R11 timers zero after enable");
    runTicks(1);
    check(1'b1, "R11 timeout after enable");

    // R12: reset clears latched fault
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1'b0, "R12 reset clears fault");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule